// File: doc/BRIEF.md
# Cursor Setup and Blink Timer

This block sits beside a display controller's command processor. It takes the parameter bytes that follow two cursor commands and keeps the cursor state that the raster logic needs. The cursor-position command loads an 18-bit cursor address one byte at a time. The cursor/character-setup command sets the following:

- whether the cursor is shown
- the number of scan lines in a character row
- whether rows are doubled
- the top and bottom cursor lines
- whether the cursor is steady or blinking
- the blink rate

A once-per-frame tick drives a blink counter. Each time the counter completes one period, a four-phase blink state advances.

The command processor marks the start of each command with `cmd_start` and a kind code. It then presents the parameter bytes with `prm_valid`. Every output comes straight from a register, so the raster side can sample any output in any cycle. `csr_visible` combines the visibility bit, the steady bit and the blink phase into one cursor-on signal. The block does not mix the cursor into pixels.

Top module: `cursor_blink_unit`

## Requirements
- R1: After synchronous reset the outputs are: `csr_addr`=0, `csr_show`=1, `csr_steady`=0, `csr_top`=0, `csr_bot`=0, `row_lines`=16, `dbl_scan`=0, `blink_rate`=32, `blink_phase`=0, `csr_visible`=1, and the blink counter is 0.
- R2: After a command start with kind 1 (position), each parameter byte updates the address in the next cycle, and the other address bits keep their values. The 1st byte sets bits 7:0, the 2nd byte sets bits 15:8, and bits 1:0 of the 3rd byte set bits 17:16.
- R3: After a command start with kind 2 (setup), the 1st byte takes effect in the next cycle. Its bit 7 sets `csr_show`, and `row_lines` becomes bits 4:0 plus 1, which is in the range 1..32.
- R4: The same 1st setup byte sets `dbl_scan` to 1 exactly when `master_mode` is 0 in that cycle and `row_lines` is greater than 1. Otherwise it sets `dbl_scan` to 0.
- R5: The 2nd setup byte is only held and changes no output. When the 3rd setup byte arrives, these outputs load together in the next cycle:
  - `csr_top` gets bits 4:0 of the 2nd byte.
  - `csr_steady` gets bit 5 of the 2nd byte.
  - `csr_bot` gets bits 7:3 of the 3rd byte.
- R6: On that same 3rd byte, a 5-bit rate field F is formed. Bits 1:0 of F are bits 7:6 of the 2nd byte, and bits 4:2 of F are bits 2:0 of the 3rd byte. `blink_rate` becomes 2×F, or 64 when F is 0.
- R7: Each `frame_tick` increments the blink counter. When the incremented value equals `blink_rate`, the counter clears and `blink_phase` advances modulo 4. Without a tick the phase holds.
- R8: If the incremented counter value has bit 6 set and does not equal `blink_rate`, the counter clears and the phase does not advance.
- R9: `csr_visible` is 1 when `csr_show` is 1 and either `csr_steady` is 1 or `blink_phase` is 0 or 1.
- R10: Parameter bytes change nothing when they follow a command start of kind 0 or 3. After the 3rd byte of any command, further bytes are also ignored.
- R11: A `frame_tick` in the same cycle as the 3rd setup byte is compared against the rate held before that byte. The counter is not cleared by a rate load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | Controller runs as sync master; suppresses row doubling |
| cmd_start | input | 1 | Start of a new command |
| cmd_kind | input | 2 | Command kind: 1 position, 2 setup, 0/3 other |
| prm_valid | input | 1 | Parameter byte present (ignored while cmd_start is high) |
| prm_data | input | 8 | Parameter byte |
| frame_tick | input | 1 | One pulse per video frame |
| csr_addr | output | 18 | Cursor address |
| csr_show | output | 1 | Cursor display enable |
| csr_steady | output | 1 | Steady (non-blinking) cursor |
| csr_top | output | 5 | Cursor top line in the row |
| csr_bot | output | 5 | Cursor bottom line in the row |
| row_lines | output | 6 | Scan lines per character row (1..32) |
| dbl_scan | output | 1 | Row doubling enable |
| blink_rate | output | 7 | Effective blink period in frames |
| blink_phase | output | 2 | Four-state blink phase |
| csr_visible | output | 1 | Cursor is currently on |

## Verification
The two functions that can coincide are the frame tick, which advances the blink counter, and the third setup byte, which loads a new blink rate. The bench builds a state where the counter sits one count below the old rate, and that count is above the new rate. It then issues the tick together with the third byte. The bench expects the phase to advance, because the tick is judged against the old rate. It then follows the later ticks to confirm that the counter continues from zero under the new rate.

// File: rtl/cblk_pkg.sv
package cblk_pkg;

    localparam int ADDR_W  = 18;
    localparam int LINE_W  = 5;
    localparam int ROW_W   = LINE_W + 1;
    localparam int RATE_W  = 7;
    localparam int CNT_W   = 7;
    localparam int PHASE_W = 2;

    typedef enum logic [1:0] {
        KIND_OTHER0 = 2'd0,
        KIND_POS    = 2'd1,
        KIND_SETUP  = 2'd2,
        KIND_OTHER3 = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        logic              show;
        logic              steady;
        logic [LINE_W-1:0] top;
        logic [LINE_W-1:0] bot;
        logic [ROW_W-1:0]  rows;
        logic              dbl;
    } cursor_shape_t;

    localparam logic [RATE_W-1:0] RATE_AT_RESET = RATE_W'(32);

    // Blink period from the 5-bit field: zero stands for 32, then doubled.
    function automatic logic [RATE_W-1:0] eff_rate(input logic [LINE_W-1:0] f);
        logic [RATE_W-1:0] base;
        base = (f == '0) ? RATE_W'(32) : RATE_W'(f);
        return base << 1;
    endfunction

endpackage

// File: rtl/cblk_param_decoder.sv
module cblk_param_decoder
    import cblk_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_kind,
    input  logic              prm_valid,
    input  logic [7:0]        prm_data,
    output logic [AW-1:0]     addr_q,
    output cursor_shape_t     shape_q,
    output logic [RATE_W-1:0] rate_q
);

    localparam int STEP_W = 2;
    localparam logic [STEP_W-1:0] STEP_DONE = 2'd3;

    cmd_kind_e         kind_q;
    logic [STEP_W-1:0] step_q;
    logic [7:0]        p2_q;
    logic              take;

    assign take = prm_valid && !cmd_start && (step_q != STEP_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q        <= KIND_OTHER0;
            step_q        <= STEP_DONE;
            p2_q          <= '0;
            addr_q        <= '0;
            shape_q.show  <= 1'b1;
            shape_q.steady<= 1'b0;
            shape_q.top   <= '0;
            shape_q.bot   <= '0;
            shape_q.rows  <= ROW_W'(16);
            shape_q.dbl   <= 1'b0;
            rate_q        <= RATE_AT_RESET;
        end else if (cmd_start) begin
            kind_q <= cmd_kind_e'(cmd_kind);
            step_q <= '0;
        end else if (take) begin
            step_q <= step_q + 1'b1;
            unique case (kind_q)
                KIND_POS: begin
                    case (step_q)
                        2'd0:    addr_q[7:0]   <= prm_data;
                        2'd1:    addr_q[15:8]  <= prm_data;
                        default: addr_q[AW-1:16] <= prm_data[AW-17:0];
                    endcase
                end
                KIND_SETUP: begin
                    case (step_q)
                        2'd0: begin
                            shape_q.show <= prm_data[7];
                            shape_q.rows <= ROW_W'(prm_data[LINE_W-1:0]) + ROW_W'(1);
                            shape_q.dbl  <= !master_mode && (prm_data[LINE_W-1:0] != '0);
                        end
                        2'd1:    p2_q <= prm_data;
                        default: begin
                            shape_q.top    <= p2_q[4:0];
                            shape_q.steady <= p2_q[5];
                            shape_q.bot    <= prm_data[7:3];
                            rate_q         <= eff_rate({prm_data[2:0], p2_q[7:6]});
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cblk_blink_timer.sv
module cblk_blink_timer
    import cblk_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PHASE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_tick,
    input  logic [RATE_W-1:0] rate,
    output logic [PW-1:0]     phase_q
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;
    logic          hit;
    logic          wrap;

    assign cnt_nx = cnt_q + 1'b1;
    assign hit    = (cnt_nx == CW'(rate));
    assign wrap   = cnt_nx[CW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= '0;
        end else if (frame_tick) begin
            if (hit) begin
                cnt_q   <= '0;
                phase_q <= phase_q + 1'b1;
            end else if (wrap) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_nx;
            end
        end
    end

endmodule

// File: rtl/cursor_blink_unit.sv
module cursor_blink_unit
    import cblk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               master_mode,
    input  logic               cmd_start,
    input  logic [1:0]         cmd_kind,
    input  logic               prm_valid,
    input  logic [7:0]         prm_data,
    input  logic               frame_tick,
    output logic [ADDR_W-1:0]  csr_addr,
    output logic               csr_show,
    output logic               csr_steady,
    output logic [LINE_W-1:0]  csr_top,
    output logic [LINE_W-1:0]  csr_bot,
    output logic [ROW_W-1:0]   row_lines,
    output logic               dbl_scan,
    output logic [RATE_W-1:0]  blink_rate,
    output logic [PHASE_W-1:0] blink_phase,
    output logic               csr_visible
);

    cursor_shape_t shape;

    cblk_param_decoder #(.AW(ADDR_W)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .master_mode(master_mode),
        .cmd_start  (cmd_start),
        .cmd_kind   (cmd_kind),
        .prm_valid  (prm_valid),
        .prm_data   (prm_data),
        .addr_q     (csr_addr),
        .shape_q    (shape),
        .rate_q     (blink_rate)
    );

    cblk_blink_timer #(.CW(CNT_W), .PW(PHASE_W)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .rate       (blink_rate),
        .phase_q    (blink_phase)
    );

    assign csr_show    = shape.show;
    assign csr_steady  = shape.steady;
    assign csr_top     = shape.top;
    assign csr_bot     = shape.bot;
    assign row_lines   = shape.rows;
    assign dbl_scan    = shape.dbl;
    assign csr_visible = shape.show && (shape.steady || !blink_phase[PHASE_W-1]);

endmodule

// File: rtl/cblk_checker.sv
module cblk_checker
    import cblk_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               master_mode,
    input logic               prm_valid,
    input logic               frame_tick,
    input logic [ADDR_W-1:0]  csr_addr,
    input logic               csr_show,
    input logic               csr_steady,
    input logic [LINE_W-1:0]  csr_top,
    input logic [LINE_W-1:0]  csr_bot,
    input logic [ROW_W-1:0]   row_lines,
    input logic               dbl_scan,
    input logic [RATE_W-1:0]  blink_rate,
    input logic [PHASE_W-1:0] blink_phase,
    input logic               csr_visible
);

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !prm_valid |=> $stable(csr_addr)); // R2

    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        (row_lines >= ROW_W'(1)) && (row_lines <= ROW_W'(32))); // R3

    AST_DBL_MASTER: assert property (@(posedge clk) disable iff (rst)
        $rose(dbl_scan) |-> !$past(master_mode)); // R4

    AST_SHAPE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !prm_valid |=> ($stable(csr_top) && $stable(csr_bot) && $stable(csr_steady))); // R5

    AST_RATE_EVEN: assert property (@(posedge clk) disable iff (rst)
        !blink_rate[0] && (blink_rate >= RATE_W'(2)) && (blink_rate <= RATE_W'(64))); // R6

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> $stable(blink_phase)); // R7

    AST_HIDDEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !csr_show |-> !csr_visible); // R9

endmodule

bind cursor_blink_unit cblk_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .master_mode(master_mode),
    .prm_valid  (prm_valid),
    .frame_tick (frame_tick),
    .csr_addr   (csr_addr),
    .csr_show   (csr_show),
    .csr_steady (csr_steady),
    .csr_top    (csr_top),
    .csr_bot    (csr_bot),
    .row_lines  (row_lines),
    .dbl_scan   (dbl_scan),
    .blink_rate (blink_rate),
    .blink_phase(blink_phase),
    .csr_visible(csr_visible)
);

// File: tb/test_cursor_blink_unit.sv
module test_cursor_blink_unit;
    import cblk_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master_mode = 1'b0;
    logic cmd_start = 1'b0;
    logic [1:0] cmd_kind = 2'd0;
    logic prm_valid = 1'b0;
    logic [7:0] prm_data = 8'h00;
    logic frame_tick = 1'b0;
    logic [ADDR_W-1:0] csr_addr;
    logic csr_show, csr_steady, dbl_scan, csr_visible;
    logic [LINE_W-1:0] csr_top, csr_bot;
    logic [ROW_W-1:0] row_lines;
    logic [RATE_W-1:0] blink_rate;
    logic [PHASE_W-1:0] blink_phase;

    always #5 clk = ~clk;

    cursor_blink_unit i_cursor_blink_unit (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .cmd_start(cmd_start), .cmd_kind(cmd_kind),
        .prm_valid(prm_valid), .prm_data(prm_data), .frame_tick(frame_tick),
        .csr_addr(csr_addr), .csr_show(csr_show), .csr_steady(csr_steady),
        .csr_top(csr_top), .csr_bot(csr_bot), .row_lines(row_lines),
        .dbl_scan(dbl_scan), .blink_rate(blink_rate),
        .blink_phase(blink_phase), .csr_visible(csr_visible)
    );

    typedef struct packed {
        logic [17:0] addr;
        logic        show;
        logic        steady;
        logic [4:0]  top;
        logic [4:0]  bot;
        logic [5:0]  rows;
        logic        dbl;
        logic [6:0]  rate;
        logic [1:0]  phase;
        logic        vis;
    } snap_t;

    typedef struct {
        snap_t exp;
        string tag;
    } item_t;

    item_t q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Reference model state, written from the requirements.
    snap_t m;
    int    m_cnt;
    int    m_kind;
    int    m_step;
    logic [7:0] m_p2;

    function automatic logic [6:0] ref_rate(input logic [4:0] f);
        int v;
        v = (f == 5'd0) ? 32 : int'(f);
        return 7'(2 * v);
    endfunction

    task automatic model_reset();
        m = '0;
        m.show = 1'b1; m.rows = 6'd16; m.rate = 7'd32; m.vis = 1'b1;
        m_cnt = 0; m_kind = 0; m_step = 3; m_p2 = 8'h00;
    endtask

    task automatic model_step(input logic cs, input logic [1:0] k, input logic pv,
                              input logic [7:0] d, input logic tk, input logic ms);
        if (tk) begin
            int n;
            n = m_cnt + 1;
            if (n == int'(m.rate)) begin m_cnt = 0; m.phase = m.phase + 2'd1; end
            else if (n >= 64) m_cnt = 0;
            else m_cnt = n;
        end
        if (cs) begin
            m_kind = int'(k); m_step = 0;
        end else if (pv && m_step < 3) begin
            if (m_kind == 1) begin
                if (m_step == 0) m.addr[7:0] = d;
                else if (m_step == 1) m.addr[15:8] = d;
                else m.addr[17:16] = d[1:0];
            end else if (m_kind == 2) begin
                if (m_step == 0) begin
                    m.show = d[7];
                    m.rows = {1'b0, d[4:0]} + 6'd1;
                    m.dbl  = !ms && (m.rows > 6'd1);
                end else if (m_step == 1) begin
                    m_p2 = d;
                end else begin
                    m.top = m_p2[4:0]; m.steady = m_p2[5];
                    m.bot = d[7:3];
                    m.rate = ref_rate({d[2:0], m_p2[7:6]});
                end
            end
            m_step = m_step + 1;
        end
        m.vis = m.show && (m.steady || (m.phase < 2'd2));
    endtask

    // Driver: one cycle of stimulus, expectation queued after the edge.
    task automatic cyc(input logic cs, input logic [1:0] k, input logic pv,
                       input logic [7:0] d, input logic tk, input logic ms, input string tag);
        item_t it;
        @(negedge clk);
        cmd_start = cs; cmd_kind = k; prm_valid = pv; prm_data = d;
        frame_tick = tk; master_mode = ms;
        model_step(cs, k, pv, d, tk, ms);
        @(posedge clk);
        #1;
        cmd_start = 1'b0; prm_valid = 1'b0; frame_tick = 1'b0;
        it.exp = m; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic start(input logic [1:0] k, input string tag);
        cyc(1'b1, k, 1'b0, 8'h00, 1'b0, master_mode, tag);
    endtask
    task automatic prm(input logic [7:0] d, input string tag);
        cyc(1'b0, 2'd0, 1'b1, d, 1'b0, master_mode, tag);
    endtask
    task automatic tick(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 1'b0, 8'h00, 1'b1, master_mode, tag);
    endtask
    task automatic setup3(input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] c, input string tag);
        start(2'd2, tag); prm(a, tag); prm(b, tag); prm(c, tag);
    endtask

    // Monitor: compare each queued expectation with the ports.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                snap_t act;
                it = q.pop_front();
                act = '{csr_addr, csr_show, csr_steady, csr_top, csr_bot, row_lines,
                        dbl_scan, blink_rate, blink_phase, csr_visible};
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc(1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, "R1");

        // R2 position bytes, R10 extra byte ignored
        start(2'd1, "R2");
        prm(8'h5A, "R2"); prm(8'hC3, "R2"); prm(8'hFE, "R2");
        prm(8'h77, "R10");
        // R10 other command kinds ignore parameters
        start(2'd0, "R10"); prm(8'hFF, "R10"); prm(8'hFF, "R10"); prm(8'hFF, "R10");
        start(2'd3, "R10"); prm(8'h81, "R10"); prm(8'hE7, "R10"); prm(8'hFF, "R10");

        // R3/R4 first setup byte
        master_mode = 1'b0;
        start(2'd2, "R3"); prm(8'h03, "R4");
        cyc(1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, "R9");
        master_mode = 1'b1;
        start(2'd2, "R4"); prm(8'h80, "R4");
        start(2'd2, "R3"); prm(8'h85, "R3");
        // R5 P2 alone changes nothing; R6 rate from split fields
        prm(8'h62, "R5");
        prm(8'h39, "R6");
        master_mode = 1'b0;
        setup3(8'h9F, 8'h00, 8'h00, "R6");

        // R7/R9 blink with rate 2
        setup3(8'h8F, 8'h40, 8'h00, "R7");
        tick(8, "R7");
        cyc(1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, "R9");
        // R9 steady cursor stays on through all phases
        setup3(8'h8F, 8'h60, 8'h00, "R9");
        tick(8, "R9");

        // R8 counter above a lowered rate wraps without advancing
        setup3(8'h8F, 8'h00, 8'h00, "R8");
        tick(40, "R8");
        setup3(8'h8F, 8'h80, 8'h00, "R8");
        tick(24, "R8");
        tick(4, "R8");

        // R11 tick coincides with the rate-loading byte
        tick(3, "R11");
        start(2'd2, "R11"); prm(8'h8F, "R11"); prm(8'h40, "R11");
        cyc(1'b0, 2'd0, 1'b1, 8'h00, 1'b1, 1'b0, "R11");
        tick(4, "R11");

        // R1 reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        cyc(1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, "R1");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule